// File: doc/BRIEF.md
# Ping-Pong Host Data Window with Byte-Lane Sequencing

This block is the processor-side data window of a 1 KiB transfer buffer that sits between a host bus and a card-side data engine. The host reaches the whole buffer through one 32-bit data location. It may use word, halfword or byte accesses, and each access is marked by a 4-bit byte-enable. An internal word pointer moves through the storage. It moves only when the host finishes a word in strictly ascending byte-lane order. Out-of-order, gapped or overreaching lane patterns are refused.

The storage holds 256 words and is split into two 128-word halves that take turns. While the card engine fills or drains one half, the host works on the other. The transfer direction and a programmable block length in bytes (1 to 512) decide when a half is complete. When the host finishes a half, the state of that half changes and the pointer jumps to the base of the other half. Accesses the host may not make raise a sticky bad-access flag and are dropped. This covers reads while read-enable is low, writes while write-enable is low, and lane-order faults.

The card side is a plain word port: a write port, an asynchronous read port, and two strobes. One strobe reports that a half has been filled for the host. The other reports that a host-written half has been consumed.

Top module: `dbuf_host_port`

## Requirements
- R1: In the first cycles after reset, `h_rdata` is zero, `bad_flag` is 0, both halves are empty, the pointer is at word 0 of half 0 with the next lane 0, `c_half_ready` is 0, and `bwe` = !`xfer_rd`, `bre` = 0.
- R2: Byte lanes are little-endian. `h_be[i]` selects bits [8i+7:8i] on both write and read.
- R3: A host access is lane-legal only under three conditions. `h_be` must be non-zero and contiguous. Its lowest set bit must equal the expected lane: lane 0 at the start of a word, otherwise one above the highest lane of the previous accepted access in that word. Its highest set bit must not exceed the word's top lane. An illegal access sets `bad_flag` and changes neither the storage nor the pointer.
- R4: The pointer advances by exactly one word when an accepted access covers the word's top lane. Consecutive words therefore land at consecutive storage addresses.
- R5: With block length L bytes, the last word of a half is word (L-1)/4 and its top lane is (L-1)%4. Every other word has top lane 3. Lanes above the top lane are illegal.
- R6: Finishing the top lane of the last word hands the half over, and the pointer moves to word 0 of the other half. A write-mode half becomes host-written, and its bit in `c_half_ready` goes to 1. A read-mode half becomes empty.
- R7: `bwe` is 1 exactly when `xfer_rd`=0 and the pointed-to half is empty. A write while `bwe`=0 sets `bad_flag`, and its data is discarded.
- R8: `bre` is 1 exactly when `xfer_rd`=1 and the pointed-to half has been filled by the card. A read while `bre`=0 sets `bad_flag` and leaves `h_rdata` unchanged.
- R9: `bad_flag` is sticky. `bad_clr` clears it on the next edge, and a new fault in the same cycle wins over the clear.
- R10: `c_fill_done` moves half `c_half` from empty to card-filled. `c_drain_done` moves it from host-written to empty. Either strobe has no effect in any other state. `c_rdata` is the word at `c_raddr`, with no clock delay. `c_wen` writes `c_wdata` to `c_waddr`.
- R11: One edge after an accepted read, `h_rdata` holds the pointed-to word with the unselected lanes zeroed. Otherwise `h_rdata` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| xfer_rd | input | 1 | 1: card-to-host transfer, 0: host-to-card |
| blk_len | input | 10 | Block length in bytes, 1 to 512 |
| h_sel | input | 1 | Host access strobe on the data window |
| h_wr | input | 1 | 1 write, 0 read |
| h_be | input | 4 | Byte-enable, bit i = lane i |
| h_wdata | input | 32 | Host write data |
| h_rdata | output | 32 | Registered host read data |
| bad_clr | input | 1 | Clear strobe for bad_flag |
| bad_flag | output | 1 | Sticky bad-access flag |
| bre | output | 1 | Buffer read enable |
| bwe | output | 1 | Buffer write enable |
| c_half | input | 1 | Half addressed by the card strobes |
| c_wen | input | 1 | Card word write |
| c_waddr | input | 8 | Card write word address |
| c_wdata | input | 32 | Card write data |
| c_raddr | input | 8 | Card read word address |
| c_rdata | output | 32 | Card read data |
| c_fill_done | input | 1 | Card has filled half c_half |
| c_drain_done | input | 1 | Card has consumed half c_half |
| c_half_ready | output | 2 | Per half: host-written, waiting for the card |

## Verification
The hardest case to reach is a lane fault on the final, partial word of a block. This means a block length that is not a multiple of four, with the host one lane short of the top or one lane over it, just as a half is about to turn over. The bench chooses short random block lengths so that halves change hands every few dozen accesses. It also replaces about one access in eight with an arbitrary byte-enable, so faults regularly land on last words and on handover cycles. Directed sequences cover a lane skip, an overreach past the final valid byte, and a write into a half still waiting for the card.

// File: rtl/dbuf_pkg.sv
package dbuf_pkg;
  // Ownership state of one buffer half
  typedef enum logic [1:0] {
    HALF_EMPTY     = 2'd0,
    HALF_HOST_DONE = 2'd1,
    HALF_CARD_DONE = 2'd2
  } half_st_e;
endpackage

// File: rtl/dbuf_lane_check.sv
module dbuf_lane_check #(
  parameter int LANES = 4,
  parameter int LW    = 2
) (
  input  logic [LANES-1:0] be,
  input  logic [LW-1:0]    exp_lane,
  input  logic [LW-1:0]    top_lane,
  output logic             legal,
  output logic             word_end,
  output logic [LW-1:0]    hi_lane
);
  logic [LW-1:0]    lo;
  logic [LW-1:0]    hi;
  logic             found;
  logic [LANES-1:0] span;

  always_comb begin
    lo    = '0;
    hi    = '0;
    found = 1'b0;
    for (int i = 0; i < LANES; i++) begin
      if (be[i]) begin
        if (!found) lo = LW'(i);
        hi    = LW'(i);
        found = 1'b1;
      end
    end
    for (int i = 0; i < LANES; i++) begin
      span[i] = (i >= int'(lo)) && (i <= int'(hi));
    end
  end

  assign legal    = found && (span == be) && (lo == exp_lane) && (hi <= top_lane);
  assign word_end = (hi == top_lane);
  assign hi_lane  = hi;
endmodule

// File: rtl/dbuf_store.sv
module dbuf_store #(
  parameter int AW = 8,
  parameter int DW = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            h_we,
  input  logic            h_re,
  input  logic [AW-1:0]   h_addr,
  input  logic [DW/8-1:0] h_be,
  input  logic [DW-1:0]   h_wdata,
  output logic [DW-1:0]   h_rdata,
  input  logic            c_we,
  input  logic [AW-1:0]   c_waddr,
  input  logic [DW-1:0]   c_wdata,
  input  logic [AW-1:0]   c_raddr,
  output logic [DW-1:0]   c_rdata
);
  localparam int LANES = DW / 8;
  localparam int WORDS = 1 << AW;

  logic [DW-1:0] mem [WORDS];
  logic [DW-1:0] lane_mask;
  logic [DW-1:0] rdata_d;
  logic [DW-1:0] rdata_q;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane_mask[g*8 +: 8] = {8{h_be[g]}};
  end

  // storage array: no reset, written by both sides
  always_ff @(posedge clk) begin
    if (c_we) mem[c_waddr] <= c_wdata;
    if (h_we) begin
      for (int i = 0; i < LANES; i++) begin
        if (h_be[i]) mem[h_addr][i*8 +: 8] <= h_wdata[i*8 +: 8];
      end
    end
  end

  assign rdata_d = mem[h_addr] & lane_mask;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
    end else if (h_re) begin
      rdata_q <= rdata_d;
    end
  end

  assign h_rdata = rdata_q;
  assign c_rdata = mem[c_raddr];
endmodule

// File: rtl/dbuf_half_ctrl.sv
module dbuf_half_ctrl
  import dbuf_pkg::*;
#(
  parameter int AW   = 8,
  parameter int LW   = 2,
  parameter int LENW = 10
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            xfer_rd,
  input  logic [LENW-1:0] blk_len,
  input  logic            acc_ok,
  input  logic            acc_wr,
  input  logic            word_end,
  input  logic [LW-1:0]   hi_lane,
  input  logic            c_half,
  input  logic            c_fill_done,
  input  logic            c_drain_done,
  output logic [AW-1:0]   ptr,
  output logic [LW-1:0]   exp_lane,
  output logic [LW-1:0]   top_lane,
  output logic            bre,
  output logic            bwe,
  output logic [1:0]      host_ready
);
  localparam int HW = AW - 1;
  localparam int NH = 2;

  half_st_e        st_q [NH];
  half_st_e        st_d [NH];
  logic [AW-1:0]   ptr_q, ptr_d;
  logic [LW-1:0]   lane_q, lane_d;
  logic [LENW-1:0] len_m1;
  logic [HW-1:0]   last_idx;
  logic            cur_half;
  logic            is_last;
  logic            half_fin;

  assign len_m1   = blk_len - 1'b1;
  assign last_idx = len_m1[LW +: HW];
  assign cur_half = ptr_q[AW-1];
  assign is_last  = (ptr_q[HW-1:0] == last_idx);
  assign top_lane = is_last ? len_m1[LW-1:0] : '1;
  assign half_fin = acc_ok && word_end && is_last;

  // next-state: pointer and lane
  always_comb begin
    ptr_d  = ptr_q;
    lane_d = lane_q;
    if (acc_ok) begin
      if (word_end) begin
        lane_d = '0;
        ptr_d  = is_last ? {~cur_half, {HW{1'b0}}} : ptr_q + 1'b1;
      end else begin
        lane_d = hi_lane + 1'b1;
      end
    end
  end

  // next-state: half ownership
  always_comb begin
    for (int g = 0; g < NH; g++) begin
      st_d[g] = st_q[g];
      if (half_fin && (cur_half == 1'(g))) begin
        st_d[g] = acc_wr ? HALF_HOST_DONE : HALF_EMPTY;
      end else if (c_fill_done && (c_half == 1'(g)) && (st_q[g] == HALF_EMPTY)) begin
        st_d[g] = HALF_CARD_DONE;
      end else if (c_drain_done && (c_half == 1'(g)) && (st_q[g] == HALF_HOST_DONE)) begin
        st_d[g] = HALF_EMPTY;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q  <= '0;
      lane_q <= '0;
      for (int g = 0; g < NH; g++) st_q[g] <= HALF_EMPTY;
    end else begin
      if (acc_ok) begin
        ptr_q  <= ptr_d;
        lane_q <= lane_d;
      end
      for (int g = 0; g < NH; g++) st_q[g] <= st_d[g];
    end
  end

  assign ptr      = ptr_q;
  assign exp_lane = lane_q;
  assign bwe      = !xfer_rd && (st_q[cur_half] == HALF_EMPTY);
  assign bre      =  xfer_rd && (st_q[cur_half] == HALF_CARD_DONE);

  for (genvar g = 0; g < NH; g++) begin : g_rdy
    assign host_ready[g] = (st_q[g] == HALF_HOST_DONE);
  end
endmodule

// File: rtl/dbuf_host_port.sv
module dbuf_host_port #(
  parameter int DW   = 32,
  parameter int AW   = 8,
  parameter int LENW = 10
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            xfer_rd,
  input  logic [LENW-1:0] blk_len,
  input  logic            h_sel,
  input  logic            h_wr,
  input  logic [DW/8-1:0] h_be,
  input  logic [DW-1:0]   h_wdata,
  output logic [DW-1:0]   h_rdata,
  input  logic            bad_clr,
  output logic            bad_flag,
  output logic            bre,
  output logic            bwe,
  input  logic            c_half,
  input  logic            c_wen,
  input  logic [AW-1:0]   c_waddr,
  input  logic [DW-1:0]   c_wdata,
  input  logic [AW-1:0]   c_raddr,
  output logic [DW-1:0]   c_rdata,
  input  logic            c_fill_done,
  input  logic            c_drain_done,
  output logic [1:0]      c_half_ready
);
  localparam int LANES = DW / 8;
  localparam int LW    = $clog2(LANES);

  logic [1:0]    rst_sync_q;
  logic          rst_n_s;
  logic [AW-1:0] hptr;
  logic [LW-1:0] exp_lane;
  logic [LW-1:0] top_lane;
  logic [LW-1:0] hi_lane;
  logic          lane_ok;
  logic          word_end;
  logic          permit;
  logic          acc_ok;
  logic          bad_d, bad_q;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_s = rst_sync_q[1];

  dbuf_lane_check #(.LANES(LANES), .LW(LW)) i_lane (
    .be       (h_be),
    .exp_lane (exp_lane),
    .top_lane (top_lane),
    .legal    (lane_ok),
    .word_end (word_end),
    .hi_lane  (hi_lane)
  );

  assign permit = h_wr ? bwe : bre;
  assign acc_ok = h_sel && permit && lane_ok;

  dbuf_half_ctrl #(.AW(AW), .LW(LW), .LENW(LENW)) i_ctrl (
    .clk          (clk),
    .rst_n        (rst_n_s),
    .xfer_rd      (xfer_rd),
    .blk_len      (blk_len),
    .acc_ok       (acc_ok),
    .acc_wr       (h_wr),
    .word_end     (word_end),
    .hi_lane      (hi_lane),
    .c_half       (c_half),
    .c_fill_done  (c_fill_done),
    .c_drain_done (c_drain_done),
    .ptr          (hptr),
    .exp_lane     (exp_lane),
    .top_lane     (top_lane),
    .bre          (bre),
    .bwe          (bwe),
    .host_ready   (c_half_ready)
  );

  dbuf_store #(.AW(AW), .DW(DW)) i_store (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .h_we    (acc_ok && h_wr),
    .h_re    (acc_ok && !h_wr),
    .h_addr  (hptr),
    .h_be    (h_be),
    .h_wdata (h_wdata),
    .h_rdata (h_rdata),
    .c_we    (c_wen),
    .c_waddr (c_waddr),
    .c_wdata (c_wdata),
    .c_raddr (c_raddr),
    .c_rdata (c_rdata)
  );

  // sticky fault: a new fault outranks the clear
  assign bad_d = (h_sel && !acc_ok) || (bad_q && !bad_clr);

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) bad_q <= 1'b0;
    else          bad_q <= bad_d;
  end

  assign bad_flag = bad_q;
endmodule

// File: rtl/dbuf_host_port_chk.sv
module dbuf_host_port_chk #(
  parameter int DW = 32,
  parameter int AW = 8
) (
  input logic          clk,
  input logic          rst_n_s,
  input logic          h_sel,
  input logic          h_wr,
  input logic          bad_clr,
  input logic          bad_flag,
  input logic          bre,
  input logic          bwe,
  input logic [DW-1:0] h_rdata,
  input logic [AW-1:0] hptr
);
  // R9
  bad_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    bad_flag && !bad_clr |=> bad_flag);

  // R7
  wr_gate_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    h_sel && h_wr && !bwe |=> bad_flag);

  // R8
  rd_gate_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    h_sel && !h_wr && !bre |=> bad_flag);

  // R7
  en_excl_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    !(bre && bwe));

  // R4
  ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (hptr != $past(hptr)) |-> ((hptr == AW'($past(hptr) + 1'b1)) || (hptr[AW-2:0] == '0)));

  // R4
  ptr_idle_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    !h_sel |=> $stable(hptr));

  // R11
  rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    !(h_sel && !h_wr) |=> $stable(h_rdata));
endmodule

bind dbuf_host_port dbuf_host_port_chk #(.DW(DW), .AW(AW)) i_chk (
  .clk      (clk),
  .rst_n_s  (rst_n_s),
  .h_sel    (h_sel),
  .h_wr     (h_wr),
  .bad_clr  (bad_clr),
  .bad_flag (bad_flag),
  .bre      (bre),
  .bwe      (bwe),
  .h_rdata  (h_rdata),
  .hptr     (hptr)
);

// File: tb/test_dbuf_host_port.sv
module test_dbuf_host_port;
  localparam int CLK_P = 10;

  logic        clk;
  logic        rst_n;
  logic        xfer_rd;
  logic [9:0]  blk_len;
  logic        h_sel, h_wr, bad_clr;
  logic [3:0]  h_be;
  logic [31:0] h_wdata, h_rdata;
  logic        bad_flag, bre, bwe;
  logic        c_half, c_wen, c_fill_done, c_drain_done;
  logic [7:0]  c_waddr, c_raddr;
  logic [31:0] c_wdata, c_rdata;
  logic [1:0]  c_half_ready;

  dbuf_host_port i_dbuf_host_port (
    .clk(clk), .rst_n(rst_n), .xfer_rd(xfer_rd), .blk_len(blk_len),
    .h_sel(h_sel), .h_wr(h_wr), .h_be(h_be), .h_wdata(h_wdata), .h_rdata(h_rdata),
    .bad_clr(bad_clr), .bad_flag(bad_flag), .bre(bre), .bwe(bwe),
    .c_half(c_half), .c_wen(c_wen), .c_waddr(c_waddr), .c_wdata(c_wdata),
    .c_raddr(c_raddr), .c_rdata(c_rdata), .c_fill_done(c_fill_done),
    .c_drain_done(c_drain_done), .c_half_ready(c_half_ready)
  );

  initial clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  // bench model of the requirements
  logic [31:0] mem_m [256];
  int          st_m [2];   // 0 empty, 1 host-written, 2 card-filled
  int          ptr_m, lane_m;
  logic        bad_m;
  logic [31:0] rd_m;
  int          n_chk, n_fail;
  bit          done;

  task automatic chk(string tg, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tg, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  endtask

  function automatic int top_of_cur();
    int lw;
    lw = (int'(blk_len) - 1) / 4;
    return ((ptr_m % 128) == lw) ? (int'(blk_len) - 1) % 4 : 3;
  endfunction

  task automatic model_edge();
    int  h, top, lo, hi, cnt;
    int  st_o [2];
    bit  lastw, perm, lgl, ok, fin;
    st_o  = st_m;
    h     = ptr_m / 128;
    lastw = ((ptr_m % 128) == (int'(blk_len) - 1) / 4);
    top   = top_of_cur();
    lo = -1; hi = -1; cnt = 0;
    for (int i = 0; i < 4; i++) if (h_be[i]) begin
      if (lo < 0) lo = i;
      hi = i;
      cnt++;
    end
    lgl  = (cnt > 0) && (cnt == hi - lo + 1) && (lo == lane_m) && (hi <= top);
    perm = h_wr ? (!xfer_rd && st_o[h] == 0) : (xfer_rd && st_o[h] == 2);
    ok   = h_sel && perm && lgl;
    fin  = 1'b0;
    if (h_sel && !ok) bad_m = 1'b1;
    else if (bad_clr) bad_m = 1'b0;
    if (ok) begin
      for (int i = 0; i < 4; i++) begin
        if (h_wr && h_be[i]) mem_m[ptr_m][i*8 +: 8] = h_wdata[i*8 +: 8];
        if (!h_wr) rd_m[i*8 +: 8] = h_be[i] ? mem_m[ptr_m][i*8 +: 8] : 8'h00;
      end
      if (hi == top) begin
        lane_m = 0;
        if (lastw) begin
          st_m[h] = h_wr ? 1 : 0;
          ptr_m   = (1 - h) * 128;
          fin     = 1'b1;
        end else ptr_m++;
      end else lane_m = hi + 1;
    end
    if (c_wen) mem_m[c_waddr] = c_wdata;
    for (int g = 0; g < 2; g++) begin
      if (!(fin && h == g)) begin
        if (c_fill_done && int'(c_half) == g && st_o[g] == 0) st_m[g] = 2;
        else if (c_drain_done && int'(c_half) == g && st_o[g] == 1) st_m[g] = 0;
      end
    end
  endtask

  task automatic tick(string tg);
    int h;
    model_edge();
    @(posedge clk);
    @(negedge clk);
    h = ptr_m / 128;
    chk({tg, " R11 rdata"}, h_rdata, rd_m);
    chk({tg, " R9 bad_flag"}, {31'd0, bad_flag}, {31'd0, bad_m});
    chk("R7 bwe", {31'd0, bwe}, {31'd0, (!xfer_rd && st_m[h] == 0)});
    chk("R8 bre", {31'd0, bre}, {31'd0, (xfer_rd && st_m[h] == 2)});
    chk("R10 c_half_ready", {30'd0, c_half_ready}, {30'd0, st_m[1] == 1, st_m[0] == 1});
    h_sel = 0; bad_clr = 0; c_wen = 0; c_fill_done = 0; c_drain_done = 0;
  endtask

  task automatic host(bit wr, logic [3:0] be, logic [31:0] d, string tg);
    h_sel = 1; h_wr = wr; h_be = be; h_wdata = d;
    tick(tg);
  endtask

  task automatic host_rand(bit wr, string tg);
    int top, hi;
    top = top_of_cur();
    h_sel = 1; h_wr = wr; h_wdata = $urandom;
    if ($urandom_range(0, 7) == 0) h_be = 4'($urandom_range(0, 15));
    else begin
      hi   = $urandom_range(lane_m, top);
      h_be = 4'(((1 << (hi + 1)) - 1) & ~((1 << lane_m) - 1));
    end
    bad_clr = ($urandom_range(0, 15) == 0);
    tick(tg);
  endtask

  // R4 R5: card view of a host-written half
  task automatic card_cmp(int g, string tg);
    int lw, tl;
    logic [31:0] msk;
    lw = (int'(blk_len) - 1) / 4;
    tl = (int'(blk_len) - 1) % 4;
    for (int w = 0; w <= lw; w++) begin
      c_raddr = 8'(g * 128 + w);
      #1;
      msk = (w == lw) ? 32'((64'd1 << (8 * (tl + 1))) - 1) : 32'hFFFF_FFFF;
      chk(tg, c_rdata & msk, mem_m[g * 128 + w] & msk);
    end
  endtask

  task automatic card_fill(int g);
    for (int w = 0; w <= (int'(blk_len) - 1) / 4; w++) begin
      c_wen = 1; c_waddr = 8'(g * 128 + w); c_wdata = $urandom;
      tick("R10 fill");
    end
    c_half = 1'(g); c_fill_done = 1;
    tick("R10 fill_done");
  endtask

  task automatic do_reset();
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    st_m[0] = 0; st_m[1] = 0; ptr_m = 0; lane_m = 0; bad_m = 0; rd_m = '0;
    // R1
    chk("R1 rdata", h_rdata, 32'd0);
    chk("R1 bad_flag", {31'd0, bad_flag}, 32'd0);
    chk("R1 bwe", {31'd0, bwe}, {31'd0, !xfer_rd});
    chk("R1 bre", {31'd0, bre}, 32'd0);
    chk("R1 ready", {30'd0, c_half_ready}, 32'd0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    n_chk = 0; n_fail = 0; done = 0;
    void'($urandom(32'h5EED));
    for (int i = 0; i < 256; i++) mem_m[i] = '0;
    xfer_rd = 0; blk_len = 10'd8;
    h_sel = 0; h_wr = 0; h_be = 0; h_wdata = 0; bad_clr = 0;
    c_half = 0; c_wen = 0; c_waddr = 0; c_wdata = 0; c_raddr = 0;
    c_fill_done = 0; c_drain_done = 0;
    do_reset();

    // R3: lane skip 0001 -> 0010 -> 1000 is refused
    host(1, 4'b0001, 32'h0000_0011, "R3");
    host(1, 4'b0010, 32'h0000_2200, "R3");
    host(1, 4'b1000, 32'hEE00_0000, "R3");
    chk("R3 skip sets bad", {31'd0, bad_flag}, 32'd1);
    bad_clr = 1; tick("R9 clear");
    chk("R9 cleared", {31'd0, bad_flag}, 32'd0);
    // R9: fault and clear in the same cycle, fault wins
    bad_clr = 1; host(1, 4'b0010, 32'h0, "R9 set-wins");
    chk("R9 set beats clear", {31'd0, bad_flag}, 32'd1);
    bad_clr = 1; tick("R9 clear");
    host(1, 4'b0100, 32'h0033_0000, "R2");
    host(1, 4'b1000, 32'h4400_0000, "R4");
    host(1, 4'b0011, 32'h0000_6655, "R2");
    host(1, 4'b1100, 32'h8877_0000, "R6");
    chk("R6 half0 handed over", {30'd0, c_half_ready}, 32'd1);
    card_cmp(0, "R2 R4 card word");
    chk("R2 word0 little-endian", mem_m[0], 32'h4433_2211);

    // R5: block of 6 bytes, last word ends at lane 1
    blk_len = 10'd6;
    host(1, 4'b1111, 32'hA1A2_A3A4, "R4");
    host(1, 4'b0111, 32'h00B3_B2B1, "R5");
    chk("R5 overreach sets bad", {31'd0, bad_flag}, 32'd1);
    host(1, 4'b0011, 32'h0000_C2C1, "R5");
    chk("R6 both halves waiting", {30'd0, c_half_ready}, 32'd3);
    card_cmp(1, "R5 card word");
    // R7: write into a half still waiting for the card
    bad_clr = 1; tick("R9");
    chk("R7 bwe low", {31'd0, bwe}, 32'd0);
    host(1, 4'b1111, 32'hDEAD_BEEF, "R7");
    chk("R7 refused write", {31'd0, bad_flag}, 32'd1);
    c_half = 0; c_fill_done = 1; tick("R10 fill ignored");
    c_half = 0; c_drain_done = 1; tick("R10 drain");
    c_half = 1; c_drain_done = 1; tick("R10 drain");
    card_cmp(0, "R7 discarded data");

    // random write traffic, two block lengths
    for (int ph = 0; ph < 2; ph++) begin
      blk_len = (ph == 0) ? 10'($urandom_range(1, 512)) : 10'($urandom_range(1, 40));
      do_reset();
      for (int n = 0; n < 2500; n++) begin
        host_rand(1, "R3");
        for (int g = 0; g < 2; g++) if (st_m[g] == 1) begin
          card_cmp(g, "R4 card word");
          c_half = 1'(g); c_drain_done = 1; tick("R10 drain");
        end
      end
    end

    // read direction
    xfer_rd = 1;
    blk_len = 10'd23;
    do_reset();
    host(0, 4'b1111, 32'h0, "R8");
    chk("R8 read without bre", {31'd0, bad_flag}, 32'd1);
    chk("R8 rdata kept", h_rdata, 32'd0);
    host(1, 4'b1111, 32'h0, "R7 write in read mode");
    for (int ph = 0; ph < 2; ph++) begin
      if (ph == 1) begin
        blk_len = 10'($urandom_range(1, 64));
        do_reset();
      end
      for (int n = 0; n < 2500; n++) begin
        if (st_m[ptr_m / 128] == 0) card_fill(ptr_m / 128);
        host_rand(0, "R3");
      end
    end
    finish_run();
  end
endmodule